// File: doc/BRIEF.md
# Fixed-Point Rounding Increment Unit

A purely combinational stage that prepares an unsigned intermediate value for a following right shift. The caller supplies the value, the count of low bits that the shift will drop (`gb`), and a two-bit rounding mode. The unit returns an adjusted value, one bit wider than its input. Shifting that value right by `gb` then yields the correctly rounded result. The unit is meant to sit in front of the shifter in averaging and narrowing-shift datapaths. Shifting, saturation and any saturation flag belong to the surrounding datapath.

Every adjustment works against two weights. `lsb` is 1 shifted left by `gb`, the weight of the lowest bit that survives the shift. `half` is `lsb` shifted right by one, the weight of the highest bit that is dropped. Two methods are used. Nearest-style modes add a weight at those positions. Round-to-odd instead ORs a one into the `lsb` position, and does so only when some discarded bit is set. Because the adder is one bit wider than the input, a carry out of the top bit is kept.

Top module: `fxp_round_inc`

## Requirements
- R1: With mode 0 (nearest, ties up), the output equals the zero-extended input plus `half`.
- R2: With mode 1 (nearest, ties to even), `lsb` is added only when the `half` bit of the input is set and, in addition, either a bit below `half` or the `lsb` bit itself is set. Otherwise the output equals the input.
- R3: With mode 2 (round down), the output equals the zero-extended input.
- R4: With mode 3 (round to odd), the `lsb` bit of the output is forced to 1 when any input bit below `lsb` is nonzero. Otherwise the output equals the input.
- R5: When `gb` is 0, the output equals the input in all four modes.
- R6: The output is `DATA_W+1` bits wide and never wraps. The output is never less than the input, and a carry out of the input's top bit appears in output bit `DATA_W`.
- R7: For every `gb` from 0 to `DATA_W-1`, the output shifted right by `gb` equals the exact quotient input/2^`gb` rounded by the selected mode's rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | DATA_W | Unsigned intermediate value before the shift |
| gb_i | input | $clog2(DATA_W) | Number of low bits the following shift drops (0 to DATA_W-1) |
| mode_i | input | 2 | Rounding mode: 0 nearest-up, 1 nearest-even, 2 down, 3 odd |
| value_o | output | DATA_W+1 | Adjusted value, ready for the right shift |

## Verification
The assertions assume three things about the inputs: they are stable, known values; the input is unsigned; and `gb_i` never exceeds `DATA_W-1`. With the default power-of-two width, every value of `gb_i` lies in that range, so the last assumption holds for any drive. The stimulus presents one input set per clock period and lets it settle before the checks read the output. It covers exact ties with both odd and even quotients, sticky bits sitting just below `half`, an all-ones input that carries out, and `gb` at 0 and at its maximum. After those directed cases it runs a long deterministic pseudo-random sweep over all four modes.

// File: rtl/fxp_round_pkg.sv
package fxp_round_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_DOWN      = 2'd2,
    RND_ODD       = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fxp_round_weights.sv
// Builds lsb/half weights and the masks of bits strictly below each.
module fxp_round_weights #(
  parameter int DATA_W = 16,
  localparam int GB_W  = $clog2(DATA_W),
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [GB_W-1:0]  gb_i,
  output logic [EXT_W-1:0] lsb_o,
  output logic [EXT_W-1:0] half_o,
  output logic [EXT_W-1:0] below_lsb_o,
  output logic [EXT_W-1:0] below_half_o
);
  always_comb begin
    lsb_o        = EXT_W'(1) << gb_i;
    half_o       = lsb_o >> 1;
    below_lsb_o  = lsb_o - EXT_W'(1);
    below_half_o = below_lsb_o >> 1; // zero when gb is 0
  end
endmodule

// File: rtl/fxp_round_detect.sv
// Extracts the bits that the rounding decision depends on.
module fxp_round_detect #(
  parameter int DATA_W = 16,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [EXT_W-1:0] value_i,
  input  logic [EXT_W-1:0] lsb_i,
  input  logic [EXT_W-1:0] half_i,
  input  logic [EXT_W-1:0] below_lsb_i,
  input  logic [EXT_W-1:0] below_half_i,
  output logic             lsb_bit_o,
  output logic             half_bit_o,
  output logic             sticky_half_o,
  output logic             sticky_lsb_o
);
  always_comb begin
    lsb_bit_o     = |(value_i & lsb_i);
    half_bit_o    = |(value_i & half_i);
    sticky_half_o = |(value_i & below_half_i);
    sticky_lsb_o  = |(value_i & below_lsb_i);
  end
endmodule

// File: rtl/fxp_round_adjust.sv
// Applies the mode-specific adjustment.
module fxp_round_adjust
  import fxp_round_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [EXT_W-1:0] value_i,
  input  rnd_mode_e        mode_i,
  input  logic [EXT_W-1:0] lsb_i,
  input  logic [EXT_W-1:0] half_i,
  input  logic             lsb_bit_i,
  input  logic             half_bit_i,
  input  logic             sticky_half_i,
  input  logic             sticky_lsb_i,
  output logic [EXT_W-1:0] value_o
);
  logic ne_up;

  always_comb begin
    ne_up = half_bit_i & (sticky_half_i | lsb_bit_i);
    unique case (mode_i)
      RND_NEAR_UP:   value_o = value_i + half_i;
      RND_NEAR_EVEN: value_o = ne_up ? value_i + lsb_i : value_i;
      RND_DOWN:      value_o = value_i;
      RND_ODD:       value_o = sticky_lsb_i ? (value_i | lsb_i) : value_i;
      default:       value_o = value_i;
    endcase
  end
endmodule

// File: rtl/fxp_round_inc.sv
module fxp_round_inc
  import fxp_round_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int GB_W  = $clog2(DATA_W),
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [GB_W-1:0]   gb_i,
  input  logic [1:0]        mode_i,
  output logic [EXT_W-1:0]  value_o
);
  logic [EXT_W-1:0] ext_val;
  logic [EXT_W-1:0] lsb_w, half_w, below_lsb_w, below_half_w;
  logic             lsb_bit, half_bit, sticky_half, sticky_lsb;
  rnd_mode_e        mode;

  assign ext_val = {1'b0, value_i};
  assign mode    = rnd_mode_e'(mode_i);

  fxp_round_weights #(.DATA_W(DATA_W)) i_weights (
    .gb_i         (gb_i),
    .lsb_o        (lsb_w),
    .half_o       (half_w),
    .below_lsb_o  (below_lsb_w),
    .below_half_o (below_half_w)
  );

  fxp_round_detect #(.DATA_W(DATA_W)) i_detect (
    .value_i       (ext_val),
    .lsb_i         (lsb_w),
    .half_i        (half_w),
    .below_lsb_i   (below_lsb_w),
    .below_half_i  (below_half_w),
    .lsb_bit_o     (lsb_bit),
    .half_bit_o    (half_bit),
    .sticky_half_o (sticky_half),
    .sticky_lsb_o  (sticky_lsb)
  );

  fxp_round_adjust #(.DATA_W(DATA_W)) i_adjust (
    .value_i       (ext_val),
    .mode_i        (mode),
    .lsb_i         (lsb_w),
    .half_i        (half_w),
    .lsb_bit_i     (lsb_bit),
    .half_bit_i    (half_bit),
    .sticky_half_i (sticky_half),
    .sticky_lsb_i  (sticky_lsb),
    .value_o       (value_o)
  );

  always_comb begin
    // R3
    round_down_pass_chk: assert (mode != RND_DOWN || value_o == ext_val)
      else $error("round down altered value");
    // R5
    zero_gb_pass_chk: assert (gb_i != '0 || value_o == ext_val)
      else $error("gb of zero altered value");
    // R6
    no_wrap_chk: assert (value_o >= ext_val)
      else $error("adjusted value wrapped");
    // R1
    near_up_step_chk: assert (mode != RND_NEAR_UP || (value_o - ext_val) < lsb_w)
      else $error("nearest-up step too large");
    // R2
    near_even_step_chk: assert (mode != RND_NEAR_EVEN ||
                                value_o == ext_val || value_o - ext_val == lsb_w)
      else $error("nearest-even step not 0 or lsb");
    // R4
    odd_jam_chk: assert (mode != RND_ODD || !sticky_lsb || (value_o & lsb_w) != '0)
      else $error("round to odd missed jam");
  end
endmodule

// File: tb/test_fxp_round_inc.sv
module test_fxp_round_inc;
  localparam int DATA_W = 16;
  localparam int GB_W   = $clog2(DATA_W);
  localparam int EXT_W  = DATA_W + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DATA_W-1:0] value_i = '0;
  logic [GB_W-1:0]   gb_i = '0;
  logic [1:0]        mode_i = 2'd2;
  logic [EXT_W-1:0]  value_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint unsigned seed = 64'h1234_5678_9abc_def1;

  always #2.5 clk = ~clk;

  fxp_round_inc #(.DATA_W(DATA_W)) i_fxp_round_inc (
    .value_i (value_i),
    .gb_i    (gb_i),
    .mode_i  (mode_i),
    .value_o (value_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (v=%0h gb=%0d mode=%0d)",
               req, act, exp, value_i, gb_i, mode_i);
    end
  endtask

  // Drive one input set, then check at the falling edge against the reference.
  task automatic apply(input longint v, input int g, input int m);
    longint q, rem, half_w, lsb_w, exp_q, exp_full;
    string req;
    @(posedge clk);
    #1;
    value_i = v[DATA_W-1:0];
    gb_i    = GB_W'(g);
    mode_i  = 2'(m);
    @(negedge clk);
    lsb_w  = 64'd1 << g;
    half_w = lsb_w / 2;
    q      = v / lsb_w;
    rem    = v % lsb_w;
    case (m)
      0: begin exp_q = q + ((g > 0 && rem >= half_w) ? 1 : 0); exp_full = v + half_w; req = "R1"; end
      1: begin
        exp_q = q + ((g > 0 && (rem > half_w || (rem == half_w && q % 2 == 1))) ? 1 : 0);
        exp_full = v + ((g > 0 && (rem > half_w || (rem == half_w && q % 2 == 1))) ? lsb_w : 0);
        req = "R2";
      end
      2: begin exp_q = q; exp_full = v; req = "R3"; end
      default: begin
        exp_q = (rem != 0) ? (q | 1) : q;
        exp_full = (rem != 0) ? (v | lsb_w) : v;
        req = "R4";
      end
    endcase
    check(req, longint'(value_o), exp_full);
    check("R7", longint'(value_o >> g), exp_q);
    if (g == 0) check("R5", longint'(value_o), v);
  endtask

  function automatic longint next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return longint'(seed >> 33);
  endfunction

  initial begin
    #20 rst_ni = 1'b1;
    @(negedge clk);
    // reset/idle state: round down of zero
    check("R3", longint'(value_o), 0);

    // R2 ties: odd quotient rounds up, even stays
    apply(16'h0018, 4, 1);
    apply(16'h0008, 4, 1);
    apply(16'h0009, 4, 1);
    apply(16'h0028, 4, 1);
    apply(16'h0038, 4, 1);
    // R1 ties and below-half
    apply(16'h0008, 4, 0);
    apply(16'h0007, 4, 0);
    // R4 jam only with nonzero discarded bits
    apply(16'h0020, 4, 3);
    apply(16'h0021, 4, 3);
    apply(16'h0031, 4, 3);
    // R3 truncate
    apply(16'h00ff, 4, 2);
    // R5 gb zero in all modes
    for (int m = 0; m < 4; m++) apply(16'hfffb, 0, m);
    // R6 carry out of top bit
    apply(16'hffff, 15, 0);
    check("R6", longint'(value_o[DATA_W]), 1);
    apply(16'hffff, 1, 1);
    check("R6", longint'(value_o), 64'h10001);
    apply(16'hc000, 15, 1);
    apply(16'hffff, 15, 3);

    for (int i = 0; i < 4000; i++)
      apply(next_rand() & 16'hffff, int'(next_rand() % DATA_W), int'(next_rand() % 4));

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule